// File: doc/BRIEF.md
# Front-Panel Change-Detect Scanner

This block watches a bank of front-panel controls and tells a host processor when one of them moves. Two kinds of control feed it: knobs, whose positions arrive already digitized as parallel multi-bit words, and single-bit switches. The block steps through every control, one per clock. It compares each reading with a shadow copy kept in a small internal table. When a reading differs from its shadow entry, the block stops stepping and raises an interrupt. The host then pulls the control number and the new reading out of a single read port.

After the host takes the second byte, the block writes the new reading into the shadow table, drops the interrupt and resumes stepping at the next control. Because the block does all the sampling itself, the host never has to poll the panel.

When reset is released, the block first tests its shadow table. It writes two address-salted patterns into the table, reads each one back, then clears the table and confirms that every entry reads zero. The resulting one-byte diagnostic is handed to the host through the same interrupt-and-read path before any scanning begins. Panel inputs are passed through a parameterized synchronizer before use.

Top module: `fpscan_top`

## Requirements
- R1: While `rst_n` is low, `host_irq` is 0 and `host_rdata` is 0x00, and the shadow table and all state are cleared.
- R2: The self-test takes exactly 6*N_CTRL clock cycles after reset release, where N_CTRL = N_KNOB + N_SW. After it, `host_irq` rises with `host_rdata` = 0x00, meaning pass. A failing step would instead give code 1, 2 or 3.
- R3: The diagnostic byte stays on `host_rdata` with `host_irq` high, whatever the panel inputs do, until the host reads it. No control is reported before that read.
- R4: A read of the diagnostic drops `host_irq` in the next cycle and starts scanning at control 0. The shadow table then holds all zeros, so only controls with a nonzero reading are reported.
- R5: Knob k has index k. When it differs from its shadow entry, `host_irq` rises. The first byte read is the index, and the second is the knob reading zero-extended to 8 bits.
- R6: Switch j has index N_KNOB+j. Its reported value is 0x00 or 0x01.
- R7: A read of the value byte drops `host_irq` in the next cycle and stores the value in the shadow table. The same reading is never reported twice.
- R8: While a report is pending, `host_irq` and `host_rdata` hold steady until the host reads. Changes made meanwhile are reported later and are not lost.
- R9: After the value byte of index i is read, scanning resumes at index i+1 and wraps after N_CTRL-1. Several pending changes are therefore reported in that circular order.
- R10: With `host_irq` low, `host_rdata` is 0x00 and a `host_rd` pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| knob_in | input | N_KNOB*KNOB_W | Digitized knob readings, knob k at bits k*KNOB_W upward |
| sw_in | input | N_SW | Switch levels, switch j at bit j |
| host_rd | input | 1 | One-cycle read strobe from the host |
| host_rdata | output | 8 | Byte currently offered to the host |
| host_irq | output | 1 | Interrupt request: a diagnostic or a change report is waiting |

## Verification
The bench sweeps every knob through every value it can hold and toggles every switch both ways. It includes steps back to a previous value. A design with a wrong zero-extension, index offset or shadow update would report bad bytes or report a change twice.

It counts the self-test length exactly and moves inputs during the self-test. A design that began scanning early or stretched the test would give the wrong timing or order.

It also stacks changes behind a pending report, including a case that wraps past the last index. A design that overwrote the pending report or resumed from the wrong index would lose a change or misorder the reports.

Idle read strobes and a reset in the middle of a report check that stray reads do nothing and that reset really clears the shadow table.

// File: rtl/fpscan_pkg.sv
package fpscan_pkg;

   typedef enum logic [2:0] {
      PH_TWR  = 3'd0,
      PH_TRD  = 3'd1,
      PH_DIAG = 3'd2,
      PH_SCAN = 3'd3,
      PH_IDX  = 3'd4,
      PH_VAL  = 3'd5
   } phase_e;

   localparam logic [1:0] LAST_PASS = 2'd2;
   localparam logic [7:0] DIAG_OK   = 8'h00;

   // Test word for a given pass and table address.
   function automatic logic [7:0] tst_word(input logic [1:0] pass, input logic [7:0] addr);
      case (pass)
         2'd0:    tst_word = 8'h55 ^ addr;
         2'd1:    tst_word = 8'hAA ^ addr;
         default: tst_word = 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/fpscan_sync.sv
module fpscan_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] sr [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) sr[i] <= '0;
         end else begin
            sr[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) sr[i] <= sr[i-1];
         end
      end
      assign q = sr[STAGES-1];
   end

endmodule

// File: rtl/fpscan_sel.sv
module fpscan_sel #(
   parameter int unsigned N_KNOB = 4,
   parameter int unsigned KNOB_W = 8,
   parameter int unsigned N_SW   = 8,
   parameter int unsigned AW     = 4
) (
   input  logic [N_KNOB*KNOB_W-1:0] knob,
   input  logic [N_SW-1:0]          sw,
   input  logic [AW-1:0]            idx,
   output logic [7:0]               val
);

   localparam int unsigned N_CTRL = N_KNOB + N_SW;

   logic [7:0] vals [N_CTRL];

   for (genvar k = 0; k < int'(N_KNOB); k++) begin : g_knob
      if (KNOB_W == 8) begin : g_full
         assign vals[k] = knob[k*KNOB_W +: KNOB_W];
      end else begin : g_ext
         assign vals[k] = {{(8-KNOB_W){1'b0}}, knob[k*KNOB_W +: KNOB_W]};
      end
   end

   for (genvar j = 0; j < int'(N_SW); j++) begin : g_sw
      assign vals[N_KNOB+j] = {7'd0, sw[j]};
   end

   always_comb begin
      val = 8'h00;
      for (int i = 0; i < int'(N_CTRL); i++) begin
         if (idx == AW'(i)) val = vals[i];
      end
   end

endmodule

// File: rtl/fpscan_table.sv
module fpscan_table #(
   parameter int unsigned DEPTH = 12,
   parameter int unsigned AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [7:0]    wd,
   input  logic [AW-1:0] ra,
   output logic [7:0]    rd
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
      end else if (we) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            if (wa == AW'(i)) mem[i] <= wd;
         end
      end
   end

   always_comb begin
      rd = 8'h00;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (ra == AW'(i)) rd = mem[i];
      end
   end

endmodule

// File: rtl/fpscan_ctrl.sv
module fpscan_ctrl
   import fpscan_pkg::*;
#(
   parameter int unsigned N_CTRL = 12,
   parameter int unsigned AW     = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_rd,
   input  logic [7:0]    cur_val,
   input  logic [7:0]    tbl_rd,
   output logic [AW-1:0] tbl_ra,
   output logic          tbl_we,
   output logic [AW-1:0] tbl_wa,
   output logic [7:0]    tbl_wd,
   output logic [AW-1:0] sel_idx,
   output phase_e        phase,
   output logic [AW-1:0] rep_idx,
   output logic [7:0]    rep_val,
   output logic [7:0]    diag
);

   localparam logic [AW-1:0] LAST = AW'(N_CTRL - 1);

   phase_e        ph_q;
   logic [AW-1:0] addr_q;
   logic [1:0]    pass_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] idx_q;
   logic [7:0]    val_q;
   logic [7:0]    diag_q;
   logic [7:0]    addr8;
   logic [7:0]    expect_w;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
      step = (p == LAST) ? '0 : p + 1'b1;
   endfunction

   always_comb begin
      addr8    = 8'h00;
      addr8[AW-1:0] = addr_q;
      expect_w = tst_word(pass_q, addr8);
   end

   assign tbl_ra  = (ph_q == PH_TRD) ? addr_q : ptr_q;
   assign sel_idx = ptr_q;
   assign tbl_we  = (ph_q == PH_TWR) || (ph_q == PH_VAL && host_rd);
   assign tbl_wa  = (ph_q == PH_TWR) ? addr_q : idx_q;
   assign tbl_wd  = (ph_q == PH_TWR) ? expect_w : val_q;

   assign phase   = ph_q;
   assign rep_idx = idx_q;
   assign rep_val = val_q;
   assign diag    = diag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_TWR;
         addr_q <= '0;
         pass_q <= 2'd0;
         ptr_q  <= '0;
         idx_q  <= '0;
         val_q  <= 8'h00;
         diag_q <= DIAG_OK;
      end else begin
         case (ph_q)
            PH_TWR: begin
               if (addr_q == LAST) begin
                  addr_q <= '0;
                  ph_q   <= PH_TRD;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            PH_TRD: begin
               if (tbl_rd != expect_w) begin
                  diag_q <= {6'd0, pass_q} + 8'd1;
                  ph_q   <= PH_DIAG;
               end else if (addr_q == LAST) begin
                  addr_q <= '0;
                  if (pass_q == LAST_PASS) begin
                     ph_q <= PH_DIAG;
                  end else begin
                     pass_q <= pass_q + 2'd1;
                     ph_q   <= PH_TWR;
                  end
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            PH_DIAG: begin
               if (host_rd) ph_q <= PH_SCAN;
            end
            PH_SCAN: begin
               if (cur_val != tbl_rd) begin
                  idx_q <= ptr_q;
                  val_q <= cur_val;
                  ph_q  <= PH_IDX;
               end else begin
                  ptr_q <= step(ptr_q);
               end
            end
            PH_IDX: begin
               if (host_rd) ph_q <= PH_VAL;
            end
            PH_VAL: begin
               if (host_rd) begin
                  ptr_q <= step(idx_q);
                  ph_q  <= PH_SCAN;
               end
            end
            default: ph_q <= PH_TWR;
         endcase
      end
   end

endmodule

// File: rtl/fpscan_top.sv
module fpscan_top
   import fpscan_pkg::*;
#(
   parameter int unsigned N_KNOB      = 4,
   parameter int unsigned KNOB_W      = 8,
   parameter int unsigned N_SW        = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_KNOB*KNOB_W-1:0] knob_in,
   input  logic [N_SW-1:0]          sw_in,
   input  logic                     host_rd,
   output logic [7:0]               host_rdata,
   output logic                     host_irq
);

   localparam int unsigned N_CTRL = N_KNOB + N_SW;
   localparam int unsigned AW     = (N_CTRL > 1) ? $clog2(N_CTRL) : 1;
   localparam int unsigned IN_W   = N_KNOB*KNOB_W + N_SW;

   initial begin : prm_chk
      assert (N_KNOB >= 1 && N_SW >= 1) else $fatal(1, "need at least one knob and one switch");
      assert (KNOB_W >= 1 && KNOB_W <= 8) else $fatal(1, "knob width must be 1..8");
      assert (N_CTRL <= 256) else $fatal(1, "index must fit in one byte");
   end

   logic [IN_W-1:0]          in_s;
   logic [N_KNOB*KNOB_W-1:0] knob_s;
   logic [N_SW-1:0]          sw_s;
   logic [AW-1:0]            sel_idx;
   logic [7:0]               cur_val;
   logic [AW-1:0]            tbl_ra;
   logic [AW-1:0]            tbl_wa;
   logic                     tbl_we;
   logic [7:0]               tbl_wd;
   logic [7:0]               tbl_rd;
   phase_e                   phase;
   logic [AW-1:0]            rep_idx;
   logic [7:0]               rep_val;
   logic [7:0]               diag;
   logic [7:0]               idx8;

   fpscan_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sw_in, knob_in}), .q(in_s)
   );

   assign knob_s = in_s[N_KNOB*KNOB_W-1:0];
   assign sw_s   = in_s[IN_W-1 -: N_SW];

   fpscan_sel #(.N_KNOB(N_KNOB), .KNOB_W(KNOB_W), .N_SW(N_SW), .AW(AW)) u_sel (
      .knob(knob_s), .sw(sw_s), .idx(sel_idx), .val(cur_val)
   );

   fpscan_table #(.DEPTH(N_CTRL), .AW(AW)) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .wa(tbl_wa), .wd(tbl_wd),
      .ra(tbl_ra), .rd(tbl_rd)
   );

   fpscan_ctrl #(.N_CTRL(N_CTRL), .AW(AW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .cur_val(cur_val),
      .tbl_rd(tbl_rd), .tbl_ra(tbl_ra), .tbl_we(tbl_we), .tbl_wa(tbl_wa),
      .tbl_wd(tbl_wd), .sel_idx(sel_idx), .phase(phase), .rep_idx(rep_idx),
      .rep_val(rep_val), .diag(diag)
   );

   always_comb begin
      idx8 = 8'h00;
      idx8[AW-1:0] = rep_idx;
   end

   always_comb begin
      case (phase)
         PH_DIAG: host_rdata = diag;
         PH_IDX:  host_rdata = idx8;
         PH_VAL:  host_rdata = rep_val;
         default: host_rdata = 8'h00;
      endcase
   end

   assign host_irq = (phase == PH_DIAG) || (phase == PH_IDX) || (phase == PH_VAL);

endmodule

// File: rtl/fpscan_chk.sv
module fpscan_chk
   import fpscan_pkg::*;
#(
   parameter int unsigned N_KNOB = 4,
   parameter int unsigned N_CTRL = 12,
   parameter int unsigned AW     = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_rd,
   input logic [7:0]    host_rdata,
   input logic          host_irq,
   input phase_e        phase,
   input logic [AW-1:0] rep_idx
);

   // R1
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!host_irq && host_rdata == 8'h00));

   // R10
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_irq |-> host_rdata == 8'h00);

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_irq && !host_rd) |=> (host_irq && $stable(host_rdata)));

   // R5
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_IDX |-> 32'(host_rdata) < N_CTRL);

   // R6
   sw_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_VAL && 32'(rep_idx) >= N_KNOB) |-> host_rdata <= 8'h01);

   // R7
   ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_VAL && host_rd) |=> !host_irq);

   // R2
   diag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_DIAG |-> host_rdata == DIAG_OK);

endmodule

bind fpscan_top fpscan_chk #(.N_KNOB(N_KNOB), .N_CTRL(N_CTRL), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_rdata(host_rdata),
   .host_irq(host_irq), .phase(phase), .rep_idx(rep_idx)
);

// File: tb/fpscan_top_tb.sv
`timescale 1ns/1ps
module fpscan_top_tb;

   localparam int NK = 3;
   localparam int KW = 4;
   localparam int NS = 4;
   localparam int NC = NK + NS;
   localparam int ST_CYC = 6 * NC;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NK*KW-1:0] knob_in = '0;
   logic [NS-1:0]  sw_in = '0;
   logic           host_rd = 1'b0;
   logic [7:0]     host_rdata;
   logic           host_irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fpscan_top #(.N_KNOB(NK), .KNOB_W(KW), .N_SW(NS), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .knob_in(knob_in), .sw_in(sw_in),
      .host_rd(host_rd), .host_rdata(host_rdata), .host_irq(host_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_knob(input int k, input int v);
      knob_in[k*KW +: KW] = KW'(v);
   endtask

   task automatic rd_pulse();
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_irq(input int maxc);
      for (int i = 0; i < maxc && !host_irq; i++) @(negedge clk);
   endtask

   task automatic expect_report(input string req, input int idx, input int val);
      wait_irq(4 * NC + 8);
      chk({req, " irq"}, int'(host_irq), 1);
      chk({req, " index"}, int'(host_rdata), idx);
      rd_pulse();
      chk({req, " value"}, int'(host_rdata), val);
      rd_pulse();
      chk({req, " irq after ack"}, int'(host_irq), 0);
   endtask

   task automatic expect_quiet(input string req, input int cyc);
      int seen = 0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (host_irq) seen = 1;
      end
      chk(req, seen, 0);
   endtask

   task automatic do_reset_and_diag(input bit timing);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1: quiet in reset
      chk("R1 irq in reset", int'(host_irq), 0);
      chk("R1 rdata in reset", int'(host_rdata), 0);
      rst_n = 1'b1;
      if (timing) begin
         // R3: inputs move during self-test
         set_knob(1, 7);
         for (int i = 1; i < ST_CYC; i++) begin
            @(negedge clk);
            if (host_irq) begin
               chk("R2 early irq", 1, 0);
               break;
            end
         end
         @(negedge clk);
         chk("R2 irq at end of self-test", int'(host_irq), 1);
      end else begin
         wait_irq(ST_CYC + 4);
      end
      chk("R2 diag byte", int'(host_rdata), 0);
      repeat (10) @(negedge clk);
      chk("R3 diag held", int'(host_irq), 1);
      chk("R3 diag byte held", int'(host_rdata), 0);
      rd_pulse();
      chk("R4 irq drops after diag read", int'(host_irq), 0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      do_reset_and_diag(1'b1);
      // R4: only the nonzero control shows up
      expect_report("R4 first report", 1, 7);
      expect_quiet("R4 no spurious report", 3 * NC);

      // R5 / R7: knob sweep over all values and back to zero
      for (int k = 0; k < NK; k++) begin
         int start = (k == 1) ? 8 : 1;
         for (int v = start; v < (1 << KW); v++) begin
            set_knob(k, v);
            expect_report("R5 knob sweep", k, v);
         end
         set_knob(k, 0);
         expect_report("R5 knob back to zero", k, 0);
         expect_quiet("R7 no repeat", 3 * NC);
      end

      // R6: switches both ways
      for (int j = 0; j < NS; j++) begin
         sw_in[j] = 1'b1;
         expect_report("R6 switch on", NK + j, 1);
         sw_in[j] = 1'b0;
         expect_report("R6 switch off", NK + j, 0);
      end
      expect_quiet("R7 no repeat after switches", 3 * NC);

      // R8 / R9: changes stacked behind a pending report
      set_knob(0, 5);
      wait_irq(4 * NC + 8);
      set_knob(2, 9);
      sw_in[1] = 1'b1;
      repeat (12) @(negedge clk);
      chk("R8 pending irq held", int'(host_irq), 1);
      chk("R8 pending index held", int'(host_rdata), 0);
      rd_pulse();
      chk("R8 pending value", int'(host_rdata), 5);
      rd_pulse();
      expect_report("R9 next in order", 2, 9);
      expect_report("R9 then switch", NK + 1, 1);

      // R9: wrap-around order
      sw_in[2] = 1'b1;
      wait_irq(4 * NC + 8);
      chk("R9 pending idx5", int'(host_rdata), NK + 2);
      set_knob(1, 3);
      sw_in[3] = 1'b1;
      repeat (6) @(negedge clk);
      rd_pulse();
      chk("R9 value idx5", int'(host_rdata), 1);
      rd_pulse();
      expect_report("R9 last index first", NK + 3, 1);
      expect_report("R9 wrapped to knob1", 1, 3);

      // R10: idle reads do nothing
      expect_quiet("R10 idle", NC);
      chk("R10 idle rdata", int'(host_rdata), 0);
      for (int i = 0; i < 5; i++) rd_pulse();
      chk("R10 irq after idle reads", int'(host_irq), 0);
      chk("R10 rdata after idle reads", int'(host_rdata), 0);
      set_knob(1, 4);
      expect_report("R10 report intact after idle reads", 1, 4);

      // R1 / R4: reset in the middle of a report clears the shadow table
      set_knob(0, 0); set_knob(1, 0); set_knob(2, 3);
      sw_in = '0;
      wait_irq(4 * NC + 8);
      do_reset_and_diag(1'b0);
      expect_report("R4 report after second reset", 2, 3);
      expect_quiet("R4 quiet after second reset", 3 * NC);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule